// File: doc/BRIEF.md
# Ping-Pong Endpoint Descriptor Engine

This block moves packet data for one device endpoint between a byte-wide buffer memory and the packet layer. Each transfer is steered by a descriptor. There are two descriptors for each direction, called even and odd. Software fills a descriptor with a status word and a buffer start address. It then hands that descriptor to the hardware by setting the ownership bit in the status word. The engine consumes the even and odd descriptors of a direction in alternation.

When a token arrives and the current descriptor of that direction is owned by the hardware, the engine runs the transfer by itself. An IN token streams the buffer bytes to the transmitter. An OUT token stores the received bytes into the buffer, up to the byte count that software allowed. On completion the engine writes the status back and returns ownership to software. It then advances to the other descriptor and raises a sticky transfer-complete interrupt. If the current descriptor is still owned by software, the engine answers the token with a NAK and changes nothing.

Token decoding, CRC checking, line coding and the physical layer are outside this block. They appear only as strobes and byte streams.

Top module: `usb_bd_engine`

## Requirements
- R1: After reset, all four descriptor status words read back as 0. Both even/odd pointers select even (0). `trn_irq`, `hs_nak`, `tx_valid`, `tx_zlp` and `mem_we` are all 0.
- R2: A software write stores the status word and the address into the descriptor selected by {`sw_dir`, `sw_odd`}, where dir 1 = IN and dir 0 = OUT. The same descriptor reads back on `rd_stat`/`rd_addr` when {`rd_dir`, `rd_odd`} selects it. Status layout (for the default counter width of 10): bit 12 is ownership (1 = hardware), bit 11 is the data toggle, bit 10 is overflow, and bits 9:0 are the byte count.
- R3: A token whose current descriptor has ownership 0 produces a one-cycle `hs_nak` in the cycle after the token. It starts no transfer, writes no descriptor, leaves both pointers unchanged and leaves `trn_irq` unchanged.
- R4: An IN token on an owned descriptor with count N>0 presents the N bytes from buffer addresses base..base+N-1 in order. The first byte appears in the cycle after the token. The stream advances only on a cycle where both `tx_valid` and `tx_ready` are 1. `tx_last` marks the final byte, and `tx_toggle` equals the stored toggle.
- R5: An OUT token on an owned descriptor with count N writes the k-th received byte (k < N) to buffer address base+k, in arrival order.
- R6: Received bytes beyond the count N are not written. The written-back status then has the overflow bit set and a count field equal to N.
- R7: Write-back happens at the clock edge that accepts the last IN byte, or at the edge that samples `rx_eop`. It clears ownership, keeps the toggle, and records the number of bytes moved. The address word is untouched.
- R8: Each completed transfer flips the pointer of its own direction only. The next token of that direction then uses the other descriptor.
- R9: Each completion sets `trn_irq`. It stays 1 until a cycle with `irq_clr` = 1 and no completion. When a completion and `irq_clr` fall in the same cycle, the flag stays set.
- R10: Tokens that arrive while a transfer is in progress are ignored: no NAK, and no effect on the running transfer.
- R11: An IN token on an owned descriptor with count 0 pulses `tx_zlp` in the next cycle. It writes back at once with count 0, and `tx_valid` stays 0.
- R12: `rx_valid` outside an OUT transfer, or in the same cycle as `rx_eop`, causes no buffer write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sw_wr | input | 1 | Software descriptor write strobe |
| sw_dir | input | 1 | Descriptor direction for write (1 = IN) |
| sw_odd | input | 1 | Descriptor parity for write (1 = odd) |
| sw_stat | input | CNT_W+3 | Status word to write |
| sw_addr | input | ADDR_W | Buffer start address to write |
| rd_dir | input | 1 | Readback direction select |
| rd_odd | input | 1 | Readback parity select |
| rd_stat | output | CNT_W+3 | Selected descriptor status word |
| rd_addr | output | ADDR_W | Selected descriptor address word |
| irq_clr | input | 1 | Write-1-to-clear for the completion flag |
| trn_irq | output | 1 | Transfer-complete level interrupt |
| ptr_in_odd | output | 1 | IN direction next-descriptor pointer |
| ptr_out_odd | output | 1 | OUT direction next-descriptor pointer |
| tok_valid | input | 1 | Token strobe from the packet layer |
| tok_in | input | 1 | Token kind (1 = IN, 0 = OUT) |
| hs_nak | output | 1 | NAK request to the packet layer |
| tx_valid | output | 1 | Transmit byte valid |
| tx_ready | input | 1 | Transmitter accepts the byte |
| tx_data | output | 8 | Transmit byte |
| tx_last | output | 1 | Final byte of the packet |
| tx_toggle | output | 1 | Data toggle of the packet |
| tx_zlp | output | 1 | Send a zero-length packet |
| rx_valid | input | 1 | Received byte valid |
| rx_data | input | 8 | Received byte |
| rx_eop | input | 1 | End of the received packet |
| mem_addr | output | ADDR_W | Buffer memory address |
| mem_we | output | 1 | Buffer memory write enable |
| mem_wdata | output | 8 | Buffer memory write data |
| mem_rdata | input | 8 | Buffer memory read data (combinational) |

## Verification
Two functions can fall in the same cycle. The write-back at completion sets the interrupt flag, and software may clear that flag with `irq_clr` on the same edge. The bench provokes this by raising `irq_clr` together with `rx_eop` and requires the flag to read 1 afterwards. A second collision is a token arriving on the first beat of an IN stream. There the bench requires no NAK and an undisturbed byte sequence. Around these cases, sweeps over IN counts 0..6 and over every pairing of OUT count 0..4 with packet length 0..6 compare the streamed bytes, the buffer contents, the sentinels past the count, and the written-back status with values computed arithmetically.

// File: rtl/usb_bd_pkg.sv
// Shared types for the endpoint descriptor engine.
// Assumes: nothing beyond IEEE 1800-2017.
package usb_bd_pkg;
    typedef enum logic [1:0] {
        XF_IDLE = 2'd0,
        XF_SEND = 2'd1,
        XF_RECV = 2'd2
    } xf_state_t;
endpackage

// File: rtl/usb_bd_store.sv
// Four descriptor slots indexed by {dir, odd}, dir 1 = IN.
// Hardware write-back takes precedence over a software write to the same slot.
// Assumes: write-back never changes the address word.
module usb_bd_store #(
    parameter int CNT_W  = 10,
    parameter int ADDR_W = 10,
    localparam int SW    = CNT_W + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_wr,
    input  logic              sw_dir,
    input  logic              sw_odd,
    input  logic [SW-1:0]     sw_stat,
    input  logic [ADDR_W-1:0] sw_addr,
    input  logic              wb_en,
    input  logic              wb_dir,
    input  logic              wb_odd,
    input  logic [SW-1:0]     wb_stat,
    input  logic              sel_in_odd,
    input  logic              sel_out_odd,
    output logic [SW-1:0]     in_stat,
    output logic [ADDR_W-1:0] in_addr,
    output logic [SW-1:0]     out_stat,
    output logic [ADDR_W-1:0] out_addr,
    input  logic              rd_dir,
    input  logic              rd_odd,
    output logic [SW-1:0]     rd_stat,
    output logic [ADDR_W-1:0] rd_addr
);
    localparam int NSLOT = 4;

    logic [SW-1:0]     stat_q [NSLOT];
    logic [ADDR_W-1:0] addr_q [NSLOT];

    // Slot update: reset, hardware write-back, or software write.
    always_ff @(posedge clk) begin
        for (int s = 0; s < NSLOT; s++) begin
            if (!rst_n) begin
                stat_q[s] <= '0;
                addr_q[s] <= '0;
            end else if (wb_en && s == int'({wb_dir, wb_odd})) begin
                stat_q[s] <= wb_stat;
            end else if (sw_wr && s == int'({sw_dir, sw_odd})) begin
                stat_q[s] <= sw_stat;
                addr_q[s] <= sw_addr;
            end
        end
    end

    // Current descriptor of each direction and the software readback view.
    always_comb begin
        in_stat  = stat_q[{1'b1, sel_in_odd}];
        in_addr  = addr_q[{1'b1, sel_in_odd}];
        out_stat = stat_q[{1'b0, sel_out_odd}];
        out_addr = addr_q[{1'b0, sel_out_odd}];
        rd_stat  = stat_q[{rd_dir, rd_odd}];
        rd_addr  = addr_q[{rd_dir, rd_odd}];
    end
endmodule

// File: rtl/usb_bd_xfer.sv
// Transfer sequencer: accepts tokens, moves bytes, and produces the write-back.
// Assumes: buffer memory reads are combinational, and rx_eop arrives in a
// cycle of its own after the data bytes.
module usb_bd_xfer
    import usb_bd_pkg::*;
#(
    parameter int CNT_W  = 10,
    parameter int ADDR_W = 10,
    localparam int SW    = CNT_W + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tok_valid,
    input  logic              tok_in,
    input  logic [SW-1:0]     in_stat,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [SW-1:0]     out_stat,
    input  logic [ADDR_W-1:0] out_addr,
    input  logic              tx_ready,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              rx_eop,
    output logic              ptr_in_odd,
    output logic              ptr_out_odd,
    output logic              hs_nak,
    output logic              tx_valid,
    output logic              tx_last,
    output logic              tx_toggle,
    output logic              tx_zlp,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic [7:0]        mem_wdata,
    output logic              wb_en,
    output logic              wb_dir,
    output logic              wb_odd,
    output logic [SW-1:0]     wb_stat
);
    localparam int OWN_B = CNT_W + 2;
    localparam int TOG_B = CNT_W + 1;

    xf_state_t         st;
    logic [ADDR_W-1:0] cur;
    logic [CNT_W-1:0]  remain, limit, nbytes;
    logic              tog, ovf, nak_q, zlp_q;

    logic             in_own, out_own, zlp_now, send_end, recv_end;
    logic [CNT_W-1:0] in_cnt, out_cnt;

    // Field extraction from the current descriptors.
    always_comb begin
        in_own  = in_stat[OWN_B];
        out_own = out_stat[OWN_B];
        in_cnt  = in_stat[CNT_W-1:0];
        out_cnt = out_stat[CNT_W-1:0];
    end

    // Completion conditions and the status word written back.
    always_comb begin
        zlp_now  = (st == XF_IDLE) && tok_valid && tok_in && in_own && (in_cnt == '0);
        send_end = (st == XF_SEND) && tx_ready && (remain == CNT_W'(1));
        recv_end = (st == XF_RECV) && rx_eop;
        wb_en    = zlp_now || send_end || recv_end;
        wb_dir   = !recv_end;
        wb_odd   = recv_end ? ptr_out_odd : ptr_in_odd;
        if (recv_end)
            wb_stat = {1'b0, tog, ovf, nbytes};
        else if (send_end)
            wb_stat = {1'b0, tog, 1'b0, limit};
        else
            wb_stat = {1'b0, in_stat[TOG_B], 1'b0, {CNT_W{1'b0}}};
    end

    // Stream and memory side outputs.
    always_comb begin
        tx_valid  = (st == XF_SEND);
        tx_last   = (st == XF_SEND) && (remain == CNT_W'(1));
        tx_toggle = tog;
        tx_zlp    = zlp_q;
        hs_nak    = nak_q;
        mem_addr  = cur;
        mem_wdata = rx_data;
        mem_we    = (st == XF_RECV) && rx_valid && !rx_eop && (nbytes < limit);
    end

    // Sequencer state, pointers and per-transfer counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st          <= XF_IDLE;
            cur         <= '0;
            remain      <= '0;
            limit       <= '0;
            nbytes      <= '0;
            tog         <= 1'b0;
            ovf         <= 1'b0;
            nak_q       <= 1'b0;
            zlp_q       <= 1'b0;
            ptr_in_odd  <= 1'b0;
            ptr_out_odd <= 1'b0;
        end else begin
            nak_q <= 1'b0;
            zlp_q <= 1'b0;
            if (wb_en && wb_dir)  ptr_in_odd  <= !ptr_in_odd;
            if (wb_en && !wb_dir) ptr_out_odd <= !ptr_out_odd;
            unique case (st)
                XF_IDLE: begin
                    if (tok_valid && tok_in) begin
                        if (!in_own) begin
                            nak_q <= 1'b1;
                        end else if (in_cnt == '0) begin
                            zlp_q <= 1'b1;
                        end else begin
                            st     <= XF_SEND;
                            cur    <= in_addr;
                            remain <= in_cnt;
                            limit  <= in_cnt;
                            tog    <= in_stat[TOG_B];
                        end
                    end else if (tok_valid) begin
                        if (!out_own) begin
                            nak_q <= 1'b1;
                        end else begin
                            st     <= XF_RECV;
                            cur    <= out_addr;
                            limit  <= out_cnt;
                            nbytes <= '0;
                            ovf    <= 1'b0;
                            tog    <= out_stat[TOG_B];
                        end
                    end
                end
                XF_SEND: begin
                    if (tx_ready) begin
                        cur    <= cur + ADDR_W'(1);
                        remain <= remain - CNT_W'(1);
                        if (remain == CNT_W'(1)) st <= XF_IDLE;
                    end
                end
                XF_RECV: begin
                    if (rx_eop) begin
                        st <= XF_IDLE;
                    end else if (rx_valid) begin
                        if (nbytes < limit) begin
                            cur    <= cur + ADDR_W'(1);
                            nbytes <= nbytes + CNT_W'(1);
                        end else begin
                            ovf <= 1'b1;
                        end
                    end
                end
                default: st <= XF_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/usb_bd_irq.sv
// Sticky transfer-complete flag with write-1-to-clear; a set wins over a clear.
// Assumes: set is a single-cycle completion strobe.
module usb_bd_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);
    // Flag register.
    always_ff @(posedge clk) begin
        if (!rst_n)   flag <= 1'b0;
        else if (set) flag <= 1'b1;
        else if (clr) flag <= 1'b0;
    end
endmodule

// File: rtl/usb_bd_engine.sv
// Top of the ping-pong endpoint descriptor engine: descriptor store,
// transfer sequencer and completion flag.
// Assumes: an external byte memory with combinational read data.
module usb_bd_engine #(
    parameter int CNT_W  = 10,
    parameter int ADDR_W = 10,
    localparam int SW    = CNT_W + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_wr,
    input  logic              sw_dir,
    input  logic              sw_odd,
    input  logic [SW-1:0]     sw_stat,
    input  logic [ADDR_W-1:0] sw_addr,
    input  logic              rd_dir,
    input  logic              rd_odd,
    output logic [SW-1:0]     rd_stat,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              irq_clr,
    output logic              trn_irq,
    output logic              ptr_in_odd,
    output logic              ptr_out_odd,
    input  logic              tok_valid,
    input  logic              tok_in,
    output logic              hs_nak,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [7:0]        tx_data,
    output logic              tx_last,
    output logic              tx_toggle,
    output logic              tx_zlp,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              rx_eop,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata
);
    logic [SW-1:0]     in_stat, out_stat, wb_stat;
    logic [ADDR_W-1:0] in_addr, out_addr;
    logic              wb_en, wb_dir, wb_odd;

    usb_bd_store #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .sw_wr(sw_wr), .sw_dir(sw_dir), .sw_odd(sw_odd),
        .sw_stat(sw_stat), .sw_addr(sw_addr),
        .wb_en(wb_en), .wb_dir(wb_dir), .wb_odd(wb_odd), .wb_stat(wb_stat),
        .sel_in_odd(ptr_in_odd), .sel_out_odd(ptr_out_odd),
        .in_stat(in_stat), .in_addr(in_addr),
        .out_stat(out_stat), .out_addr(out_addr),
        .rd_dir(rd_dir), .rd_odd(rd_odd), .rd_stat(rd_stat), .rd_addr(rd_addr)
    );

    usb_bd_xfer #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_xfer (
        .clk(clk), .rst_n(rst_n),
        .tok_valid(tok_valid), .tok_in(tok_in),
        .in_stat(in_stat), .in_addr(in_addr),
        .out_stat(out_stat), .out_addr(out_addr),
        .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_data(rx_data), .rx_eop(rx_eop),
        .ptr_in_odd(ptr_in_odd), .ptr_out_odd(ptr_out_odd),
        .hs_nak(hs_nak), .tx_valid(tx_valid), .tx_last(tx_last),
        .tx_toggle(tx_toggle), .tx_zlp(tx_zlp),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
        .wb_en(wb_en), .wb_dir(wb_dir), .wb_odd(wb_odd), .wb_stat(wb_stat)
    );

    usb_bd_irq u_irq (
        .clk(clk), .rst_n(rst_n), .set(wb_en), .clr(irq_clr), .flag(trn_irq)
    );

    // Transmit data comes straight from the buffer memory.
    always_comb tx_data = mem_rdata;
endmodule

// File: rtl/usb_bd_engine_chk.sv
// Protocol checker for usb_bd_engine, attached by bind.
// Assumes: synchronous active-low reset.
module usb_bd_engine_chk (
    input logic clk,
    input logic rst_n,
    input logic wb_en,
    input logic wb_dir,
    input logic irq_clr,
    input logic trn_irq,
    input logic ptr_in_odd,
    input logic ptr_out_odd,
    input logic hs_nak,
    input logic tx_valid,
    input logic tx_last,
    input logic mem_we
);
    // R9: a completion leaves the flag set, whatever irq_clr does.
    p_flag_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |=> trn_irq);

    // R9: a clear without a completion drops the flag.
    p_flag_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clr && !wb_en) |=> !trn_irq);

    // R8: an IN completion flips the IN pointer.
    p_in_ptr_flip_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_en && wb_dir) |=> (ptr_in_odd != $past(ptr_in_odd)));

    // R8: without a completion neither pointer moves.
    p_ptr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wb_en |=> ($stable(ptr_in_odd) && $stable(ptr_out_odd)));

    // R3: a NAK cycle carries no transfer activity and no write-back.
    p_nak_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hs_nak |-> (!tx_valid && !mem_we && !wb_en));

    // R4: the last marker only rides on a valid byte.
    p_last_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_last |-> tx_valid);

    // R12: buffer writes never overlap a transmit stream.
    p_we_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !tx_valid);
endmodule

bind usb_bd_engine usb_bd_engine_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wb_en(wb_en), .wb_dir(wb_dir),
    .irq_clr(irq_clr), .trn_irq(trn_irq),
    .ptr_in_odd(ptr_in_odd), .ptr_out_odd(ptr_out_odd),
    .hs_nak(hs_nak), .tx_valid(tx_valid), .tx_last(tx_last), .mem_we(mem_we)
);

// File: tb/usb_bd_engine_test.sv
module usb_bd_engine_test;
    localparam int CNT_W  = 10;
    localparam int ADDR_W = 10;
    localparam int SW     = CNT_W + 3;
    localparam int OWN_B  = CNT_W + 2;
    localparam int TOG_B  = CNT_W + 1;
    localparam int OVF_B  = CNT_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sw_wr = 0, sw_dir = 0, sw_odd = 0;
    logic [SW-1:0] sw_stat = '0;
    logic [ADDR_W-1:0] sw_addr = '0;
    logic rd_dir = 0, rd_odd = 0;
    logic [SW-1:0] rd_stat;
    logic [ADDR_W-1:0] rd_addr;
    logic irq_clr = 0, trn_irq, ptr_in_odd, ptr_out_odd;
    logic tok_valid = 0, tok_in = 0, hs_nak;
    logic tx_valid, tx_ready = 0, tx_last, tx_toggle, tx_zlp;
    logic [7:0] tx_data;
    logic rx_valid = 0, rx_eop = 0;
    logic [7:0] rx_data = '0;
    logic [ADDR_W-1:0] mem_addr;
    logic mem_we;
    logic [7:0] mem_wdata, mem_rdata;

    logic [7:0] mem [1<<ADDR_W];
    logic tb_we = 0;
    logic [ADDR_W-1:0] tb_a = '0;
    logic [7:0] tb_d = '0;

    int n_chk = 0, n_fail = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    usb_bd_engine #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) uut (.*);

    // Bench buffer memory: pattern at reset, engine writes, bench writes.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int a = 0; a < (1<<ADDR_W); a++) mem[a] <= 8'(a * 7 + 3);
        end else if (mem_we) begin
            mem[mem_addr] <= mem_wdata;
        end else if (tb_we) begin
            mem[tb_a] <= tb_d;
        end
    end
    assign mem_rdata = mem[mem_addr];

    function automatic logic [7:0] mpat(int a);
        return 8'(a * 7 + 3);
    endfunction
    function automatic logic [7:0] dpat(int c, int i);
        return 8'(c * 31 + i * 13 + 5);
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            finish_run();
        end
    end

    task automatic write_desc(input bit dir, input bit odd, input logic [SW-1:0] st, input int addr);
        @(negedge clk);
        sw_wr = 1; sw_dir = dir; sw_odd = odd; sw_stat = st; sw_addr = ADDR_W'(addr);
        @(negedge clk);
        sw_wr = 0;
        rd_dir = dir; rd_odd = odd; #1;
        chk(rd_stat == st, "R2 stat readback", rd_stat, st);
        chk(rd_addr == ADDR_W'(addr), "R2 addr readback", rd_addr, addr);
    endtask

    task automatic readback(input bit dir, input bit odd, input logic [SW-1:0] exp, input string req);
        rd_dir = dir; rd_odd = odd; #1;
        chk(rd_stat == exp, req, rd_stat, exp);
    endtask

    task automatic clear_flag();
        @(negedge clk); irq_clr = 1;
        @(negedge clk); irq_clr = 0;
        chk(trn_irq == 1'b0, "R9 flag cleared", trn_irq, 0);
    endtask

    task automatic token(input bit is_in);
        @(negedge clk); tok_valid = 1; tok_in = is_in;
        @(negedge clk); tok_valid = 0;
    endtask

    bit ep_in = 0, ep_out = 0;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(trn_irq == 0 && hs_nak == 0 && tx_valid == 0 && tx_zlp == 0 && mem_we == 0,
            "R1 outputs idle", {trn_irq, hs_nak, tx_valid, tx_zlp, mem_we}, 0);
        chk(ptr_in_odd == 0 && ptr_out_odd == 0, "R1 pointers even", {ptr_in_odd, ptr_out_odd}, 0);
        for (int d = 0; d < 4; d++) readback(d[1], d[0], '0, "R1 descriptor cleared");

        // R3 NAK on software-owned descriptors, both directions
        for (int k = 0; k < 2; k++) begin
            write_desc(k[0], 1'b0, SW'(5), 40);
            token(k[0]);
            chk(hs_nak == 1, "R3 nak pulse", hs_nak, 1);
            @(negedge clk);
            chk(hs_nak == 0, "R3 nak one cycle", hs_nak, 0);
            chk(ptr_in_odd == 0 && ptr_out_odd == 0 && trn_irq == 0, "R3 no state change",
                {ptr_in_odd, ptr_out_odd, trn_irq}, 0);
            readback(k[0], 1'b0, SW'(5), "R3 descriptor untouched");
        end

        // R12 rx bytes outside a transfer
        @(negedge clk); rx_valid = 1; rx_data = 8'h77; #1;
        chk(mem_we == 0, "R12 idle rx no write", mem_we, 0);
        @(negedge clk); rx_valid = 0;

        // IN sweep: counts 0..6, stalls and a stray token on the first beat
        for (int c = 0; c <= 6; c++) begin
            int base;
            bit tg;
            logic [SW-1:0] st;
            base = c * 37 + (ep_in ? 100 : 0);
            tg = c[0];
            st = '0; st[OWN_B] = 1; st[TOG_B] = tg; st[CNT_W-1:0] = CNT_W'(c);
            write_desc(1'b1, ep_in, st, base);
            token(1'b1);
            if (c == 0) begin
                chk(tx_zlp == 1 && tx_valid == 0, "R11 zero-length pulse", {tx_zlp, tx_valid}, 2);
            end else begin
                for (int i = 0; i < c; i++) begin
                    if (i == 0) begin tok_valid = 1; tok_in = 0; end
                    if (i % 3 == 1) begin
                        tx_ready = 0;
                        @(negedge clk);
                        chk(tx_valid && tx_data == mpat(base + i), "R4 stall holds byte", tx_data, mpat(base + i));
                    end
                    tx_ready = 1; #1;
                    chk(tx_valid == 1, "R4 valid", tx_valid, 1);
                    chk(tx_data == mpat(base + i), "R4 byte", tx_data, mpat(base + i));
                    chk(tx_last == (i == c - 1), "R4 last", tx_last, (i == c - 1));
                    chk(tx_toggle == tg, "R4 toggle", tx_toggle, tg);
                    @(negedge clk);
                    tok_valid = 0;
                    if (i == 0) chk(hs_nak == 0, "R10 token ignored in transfer", hs_nak, 0);
                end
                tx_ready = 0;
                chk(tx_valid == 0, "R4 stream ended", tx_valid, 0);
            end
            st[OWN_B] = 0;
            readback(1'b1, ep_in, st, "R7 IN write-back");
            chk(trn_irq == 1, "R9 flag set IN", trn_irq, 1);
            ep_in = !ep_in;
            chk(ptr_in_odd == ep_in && ptr_out_odd == ep_out, "R8 IN pointer", {ptr_in_odd, ptr_out_odd}, {ep_in, ep_out});
            @(negedge clk); @(negedge clk);
            chk(trn_irq == 1, "R9 flag sticky", trn_irq, 1);
            clear_flag();
        end

        // OUT sweep: count 0..4 against packet length 0..6
        for (int c = 0; c <= 4; c++) begin
            for (int n = 0; n <= 6; n++) begin
                int base, got;
                bit tg;
                logic [SW-1:0] st, exp;
                base = 600 + c * 50 + n * 7;
                tg = n[0];
                for (int k = 0; k < 8; k++) begin
                    @(negedge clk); tb_we = 1; tb_a = ADDR_W'(base + k); tb_d = 8'hA5;
                end
                @(negedge clk); tb_we = 0;
                st = '0; st[OWN_B] = 1; st[TOG_B] = tg; st[CNT_W-1:0] = CNT_W'(c);
                write_desc(1'b0, ep_out, st, base);
                token(1'b0);
                for (int i = 0; i < n; i++) begin
                    rx_valid = 1; rx_data = dpat(c, i); #1;
                    chk(mem_we == (i < c), "R6 write gate", mem_we, (i < c));
                    @(negedge clk);
                end
                rx_valid = 0; rx_eop = 1;
                if (c == 2 && n == 2) irq_clr = 1;
                @(negedge clk);
                rx_eop = 0; irq_clr = 0;
                got = (n < c) ? n : c;
                exp = '0; exp[TOG_B] = tg; exp[OVF_B] = (n > c); exp[CNT_W-1:0] = CNT_W'(got);
                readback(1'b0, ep_out, exp, "R6 R7 OUT write-back");
                for (int k = 0; k < 8; k++) begin
                    logic [7:0] e;
                    e = (k < got) ? dpat(c, k) : 8'hA5;
                    chk(mem[base + k] == e, (k < got) ? "R5 stored byte" : "R6 byte past count untouched", mem[base + k], e);
                end
                chk(trn_irq == 1, (c == 2 && n == 2) ? "R9 set beats clear" : "R9 flag set OUT", trn_irq, 1);
                ep_out = !ep_out;
                chk(ptr_out_odd == ep_out && ptr_in_odd == ep_in, "R8 OUT pointer", {ptr_in_odd, ptr_out_odd}, {ep_in, ep_out});
                clear_flag();
            end
        end

        // R12 rx_valid together with rx_eop writes nothing
        write_desc(1'b0, ep_out, {1'b1, 1'b0, 1'b0, CNT_W'(3)}, 900);
        token(1'b0);
        rx_valid = 1; rx_eop = 1; rx_data = 8'h3C; #1;
        chk(mem_we == 0, "R12 byte with eop ignored", mem_we, 0);
        @(negedge clk); rx_valid = 0; rx_eop = 0;
        readback(1'b0, ep_out, '0, "R12 zero bytes recorded");
        clear_flag();

        finish_run();
    end
endmodule